// File: doc/BRIEF.md
# Explicit-Length Packed String Comparator

This unit compares two 128-bit string fragments element by element and returns a 128-bit result mask. Each fragment comes with its own signed length. Only elements that fall inside the clamped length of their fragment count as valid. An 8-bit control byte sets five things: the element size (16 bytes or 8 words), signed or unsigned element values, one of four aggregation modes, the result polarity, and whether the result is packed into low bits or spread across whole elements.

A caller raises `in_valid` for one cycle with the operands. The mask appears on `out_mask` in the next cycle, with `out_valid` high for that cycle. There is no back-pressure, and a strobe may be given every cycle. A two-state controller drives the result-valid timing. `ST_IDLE` moves to `ST_EMIT` on a strobe (transition *accept*) and stays in `ST_IDLE` when there is none. `ST_EMIT` stays in `ST_EMIT` on a new strobe (*chain*) or returns to `ST_IDLE` (*retire*). The result register holds its value until the next strobe.

In the text below, "first operand" means `a_data`/`a_len` and "second operand" means `b_data`/`b_len`. N is the element count (16 or 8). La and Lb are the effective lengths.

Top module: `strcmp_unit`

## Requirements
- R1: Control bit 0 selects the element layout. At 0 there are 16 byte elements; element i is bits [8i+7:8i]. At 1 there are 8 word elements; element i is bits [16i+15:16i].
- R2: The effective length of each operand depends on `len_wide`. At 0 the length is the low 32 bits of its length input as a signed value, and the upper bits are ignored. At 1 the full 64 bits are a signed value. The effective length is the absolute value of that signed value. It becomes N when the value is greater than N or less than -N. An element is valid when its index is below the effective length.
- R3: Control bits 3:2 = 00 (equal-any): result bit j is 1 when second-operand element j is valid and equals some valid first-operand element.
- R4: Control bits 3:2 = 01 (ranges): result bit j is 1 when second-operand element j is valid and lies inclusively between first-operand elements 2m (lower bound) and 2m+1 (upper bound) for some m with both bounds valid. Control bit 1 = 1 compares as two's-complement; 0 compares as unsigned.
- R5: Control bits 3:2 = 10 (equal-each): bit j is (a[j] == b[j]) when both elements are valid. It is 1 when both are invalid and 0 when exactly one is invalid.
- R6: Control bits 3:2 = 11 (equal-ordered): bit j is the AND over k of match(a[k], b[j+k]) for k from 0 while j+k < N. match is 1 when a[k] is invalid, 0 when a[k] is valid and b[j+k] is invalid, and equality otherwise.
- R7: Control bits 5:4 set the polarity. 00 and 10 leave the result unchanged. 01 inverts bits 0..N-1. 11 inverts only the bits j < Lb.
- R8: With control bit 6 = 0, bit j of `out_mask` is result bit j for j < N, and every other bit is 0.
- R9: With control bit 6 = 1, every bit of element j in `out_mask` (8 bits in byte mode, 16 bits in word mode) equals result bit j.
- R10: `out_valid` is high exactly in the cycle after each cycle with `in_valid` high. `out_mask` changes only after a strobe and holds its value otherwise. Reset clears both to 0.
- R11: Control bit 7 has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle strobe that accepts the operands |
| ctrl | input | 8 | Control byte: size, sign, mode, polarity, format |
| len_wide | input | 1 | 1: 64-bit length values, 0: 32-bit length values |
| a_data | input | 128 | First operand elements |
| a_len | input | 64 | First operand signed length |
| b_data | input | 128 | Second operand elements |
| b_len | input | 64 | Second operand signed length |
| out_valid | output | 1 | High for one cycle per accepted strobe |
| out_mask | output | 128 | Registered result mask |

## Verification
The controller holds a single state bit. If it drifts, `out_valid` shows a missing or extra pulse in the very next cycle, and the scoreboard then finds either an empty queue or a stale entry. The result register is loaded only on a strobe. A wrong value therefore appears one cycle after the strobe that caused it. A register that loads when it should not shows up as a changed `out_mask` during idle cycles. Datapath faults stay hidden until the control byte selects the faulty mode, size or format, or until lengths hit a clamp boundary. For that reason the stimulus mixes every control combination with lengths at zero, at N, beyond N, negative, and with garbage in the upper length bits.

// File: rtl/strcmp_pkg.sv
package strcmp_pkg;

    typedef enum logic [1:0] {
        AGG_EQ_ANY = 2'b00,
        AGG_RANGES = 2'b01,
        AGG_EQ_EACH = 2'b10,
        AGG_EQ_ORD = 2'b11
    } agg_mode_e;

    // Field order follows control bits 6..0
    typedef struct packed {
        logic       fmt_expand;
        logic [1:0] polarity;
        agg_mode_e  agg;
        logic       is_signed;
        logic       is_word;
    } cmp_cfg_t;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } emit_state_e;

endpackage

// File: rtl/strcmp_len_clamp.sv
module strcmp_len_clamp #(
    parameter int LEN_W    = 64,
    parameter int NARROW_W = 32,
    parameter int CNT_W    = 5
) (
    input  logic [LEN_W-1:0] len_raw,
    input  logic             wide,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] len_eff
);
    logic signed [LEN_W-1:0] val;
    logic signed [LEN_W-1:0] lim;
    logic signed [LEN_W-1:0] mag;

    always_comb begin
        val = wide ? len_raw
                   : {{(LEN_W-NARROW_W){len_raw[NARROW_W-1]}}, len_raw[NARROW_W-1:0]};
        lim = {{(LEN_W-CNT_W){1'b0}}, limit};
        mag = (val < 0) ? -val : val;
        // Compare against both bounds so the most negative value never overflows
        if ((val > lim) || (val < -lim)) begin
            len_eff = limit;
        end else begin
            len_eff = mag[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/strcmp_core.sv
module strcmp_core
    import strcmp_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int MAX_EL = VEC_W / 8,
    parameter int CNT_W  = $clog2(MAX_EL + 1)
) (
    input  logic [VEC_W-1:0]  a_data,
    input  logic [VEC_W-1:0]  b_data,
    input  cmp_cfg_t          cfg,
    input  logic [CNT_W-1:0]  a_cnt,
    input  logic [CNT_W-1:0]  b_cnt,
    input  logic [CNT_W-1:0]  n_el,
    output logic [MAX_EL-1:0] agg_res
);
    localparam int WORD_EL = MAX_EL / 2;
    localparam int EW      = 17;

    logic signed [EW-1:0] ea [MAX_EL];
    logic signed [EW-1:0] eb [MAX_EL];
    logic [MAX_EL-1:0]    av, bv, lane;
    logic [MAX_EL-1:0]    raw_res, pol_res;

    for (genvar g = 0; g < MAX_EL; g++) begin : g_elem
        logic [15:0] ra, rb;
        logic        sa, sb;
        if (g < WORD_EL) begin : g_dual
            assign ra = cfg.is_word ? a_data[16*g +: 16] : {8'h00, a_data[8*g +: 8]};
            assign rb = cfg.is_word ? b_data[16*g +: 16] : {8'h00, b_data[8*g +: 8]};
        end else begin : g_byte
            assign ra = {8'h00, a_data[8*g +: 8]};
            assign rb = {8'h00, b_data[8*g +: 8]};
        end
        assign sa    = cfg.is_signed & (cfg.is_word ? ra[15] : ra[7]);
        assign sb    = cfg.is_signed & (cfg.is_word ? rb[15] : rb[7]);
        assign ea[g] = cfg.is_word ? {sa, ra} : {{9{sa}}, ra[7:0]};
        assign eb[g] = cfg.is_word ? {sb, rb} : {{9{sb}}, rb[7:0]};
        assign av[g]   = CNT_W'(g) < a_cnt;
        assign bv[g]   = CNT_W'(g) < b_cnt;
        assign lane[g] = CNT_W'(g) < n_el;
    end

    always_comb begin
        raw_res = '0;
        unique case (cfg.agg)
            AGG_EQ_ANY: begin
                for (int j = 0; j < MAX_EL; j++)
                    for (int i = 0; i < MAX_EL; i++)
                        if (av[i] && bv[j] && (ea[i] == eb[j])) raw_res[j] = 1'b1;
            end
            AGG_RANGES: begin
                for (int j = 0; j < MAX_EL; j++)
                    for (int p = 0; p < WORD_EL; p++)
                        if (av[2*p+1] && bv[j] && (ea[2*p] <= eb[j]) && (eb[j] <= ea[2*p+1]))
                            raw_res[j] = 1'b1;
            end
            AGG_EQ_EACH: begin
                for (int j = 0; j < MAX_EL; j++)
                    raw_res[j] = (av[j] && bv[j]) ? (ea[j] == eb[j]) : (!av[j] && !bv[j]);
            end
            AGG_EQ_ORD: begin
                for (int j = 0; j < MAX_EL; j++) begin
                    raw_res[j] = 1'b1;
                    for (int k = 0; k < MAX_EL; k++) begin
                        if ((j + k) < int'(n_el) && av[k]) begin
                            if (!bv[j+k] || (ea[k] != eb[j+k])) raw_res[j] = 1'b0;
                        end
                    end
                end
            end
            default: raw_res = '0;
        endcase
    end

    always_comb begin
        unique case (cfg.polarity)
            2'b01:   pol_res = ~raw_res;
            2'b11:   pol_res = raw_res ^ bv;
            default: pol_res = raw_res;
        endcase
        agg_res = pol_res & lane;
    end
endmodule

// File: rtl/strcmp_format.sv
module strcmp_format #(
    parameter int VEC_W  = 128,
    parameter int MAX_EL = VEC_W / 8
) (
    input  logic [MAX_EL-1:0] res,
    input  logic              is_word,
    input  logic              expand,
    output logic [VEC_W-1:0]  mask
);
    localparam int WORD_EL = MAX_EL / 2;

    logic [VEC_W-1:0] byte_exp, word_exp;

    for (genvar g = 0; g < MAX_EL; g++) begin : g_bexp
        assign byte_exp[8*g +: 8] = {8{res[g]}};
    end
    for (genvar g = 0; g < WORD_EL; g++) begin : g_wexp
        assign word_exp[16*g +: 16] = {16{res[g]}};
    end

    always_comb begin
        if (!expand)      mask = VEC_W'(res);
        else if (is_word) mask = word_exp;
        else              mask = byte_exp;
    end
endmodule

// File: rtl/strcmp_unit.sv
module strcmp_unit
    import strcmp_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int LEN_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       ctrl,
    input  logic             len_wide,
    input  logic [VEC_W-1:0] a_data,
    input  logic [LEN_W-1:0] a_len,
    input  logic [VEC_W-1:0] b_data,
    input  logic [LEN_W-1:0] b_len,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_mask
);
    localparam int MAX_EL  = VEC_W / 8;
    localparam int WORD_EL = MAX_EL / 2;
    localparam int CNT_W   = $clog2(MAX_EL + 1);

    cmp_cfg_t         cfg;
    logic             ctrl_unused;
    logic [CNT_W-1:0] n_el, a_cnt, b_cnt;
    logic [MAX_EL-1:0] agg_res;
    logic [VEC_W-1:0] fmt_mask;
    emit_state_e      state_q, state_d;
    logic [VEC_W-1:0] mask_q;

    assign cfg         = cmp_cfg_t'(ctrl[6:0]);
    assign ctrl_unused = ctrl[7];
    assign n_el        = cfg.is_word ? CNT_W'(WORD_EL) : CNT_W'(MAX_EL);

    strcmp_len_clamp #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_clamp_a (
        .len_raw(a_len), .wide(len_wide), .limit(n_el), .len_eff(a_cnt)
    );
    strcmp_len_clamp #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_clamp_b (
        .len_raw(b_len), .wide(len_wide), .limit(n_el), .len_eff(b_cnt)
    );

    strcmp_core #(.VEC_W(VEC_W), .MAX_EL(MAX_EL), .CNT_W(CNT_W)) u_core (
        .a_data(a_data), .b_data(b_data), .cfg(cfg),
        .a_cnt(a_cnt), .b_cnt(b_cnt), .n_el(n_el), .agg_res(agg_res)
    );

    strcmp_format #(.VEC_W(VEC_W), .MAX_EL(MAX_EL)) u_fmt (
        .res(agg_res), .is_word(cfg.is_word), .expand(cfg.fmt_expand), .mask(fmt_mask)
    );

    // Next-state logic: accept / chain / retire
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) mask_q <= fmt_mask;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_EMIT);
        out_mask  = mask_q;
    end

    function automatic logic words_uniform(input logic [VEC_W-1:0] m);
        for (int w = 0; w < WORD_EL; w++)
            if ((m[16*w +: 16] != '0) && (m[16*w +: 16] != '1)) return 1'b0;
        return 1'b1;
    endfunction

    assert_valid_follows_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_mask_held_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_mask));
    assert_compact_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ctrl[6]) |=> (out_mask[VEC_W-1:MAX_EL] == '0));
    assert_word_expand_uniform_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl[6] && ctrl[0]) |=> words_uniform(out_mask));
endmodule

// File: tb/strcmp_unit_bench.sv
module strcmp_unit_bench;
    typedef struct {
        logic [127:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   ctrl = '0;
    logic         len_wide = 1'b1;
    logic [127:0] a_data = '0, b_data = '0;
    logic [63:0]  a_len = '0, b_len = '0;
    logic         out_valid;
    logic [127:0] out_mask;

    item_t        sb_q[$];
    int           n_cmp = 0, n_bad = 0;
    logic [127:0] last_exp = '0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    strcmp_unit u_strcmp_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctrl(ctrl), .len_wide(len_wide),
        .a_data(a_data), .a_len(a_len), .b_data(b_data), .b_len(b_len),
        .out_valid(out_valid), .out_mask(out_mask)
    );

    // ---------------- reference model, written from the requirements ----------------
    function automatic int eff_len(logic [63:0] raw, bit wide, int n);
        longint v;
        v = wide ? longint'(raw) : longint'(int'(raw[31:0]));
        if (v > n || v < -n) return n;
        return (v < 0) ? int'(-v) : int'(v);
    endfunction

    function automatic int elem(logic [127:0] d, int i, bit word, bit sgn);
        if (word) return sgn ? int'(shortint'(d[16*i +: 16])) : int'({16'h0, d[16*i +: 16]});
        return sgn ? int'(byte'(d[8*i +: 8])) : int'({24'h0, d[8*i +: 8]});
    endfunction

    function automatic logic [127:0] model(logic [7:0] c, logic [127:0] a, logic [63:0] la_raw,
                                           logic [127:0] b, logic [63:0] lb_raw, bit wide);
        int n, la, lb;
        bit w, s;
        logic [15:0]  r;
        logic [127:0] m;
        w = c[0]; s = c[1];
        n = w ? 8 : 16;
        la = eff_len(la_raw, wide, n);
        lb = eff_len(lb_raw, wide, n);
        r = '0; m = '0;
        for (int j = 0; j < n; j++) begin
            case (c[3:2])
                2'b00: for (int i = 0; i < la; i++)
                           if (j < lb && elem(a, i, w, s) == elem(b, j, w, s)) r[j] = 1'b1;
                2'b01: for (int i = 0; i + 1 < la; i += 2)
                           if (j < lb && elem(a, i, w, s) <= elem(b, j, w, s)
                               && elem(b, j, w, s) <= elem(a, i + 1, w, s)) r[j] = 1'b1;
                2'b10: r[j] = (j < la && j < lb) ? (elem(a, j, w, s) == elem(b, j, w, s))
                                                 : (j >= la && j >= lb);
                default: begin
                    r[j] = 1'b1;
                    for (int k = 0; j + k < n; k++)
                        if (k < la && (j + k >= lb || elem(a, k, w, s) != elem(b, j + k, w, s)))
                            r[j] = 1'b0;
                end
            endcase
            if (c[5:4] == 2'b01) r[j] = ~r[j];
            if (c[5:4] == 2'b11 && j < lb) r[j] = ~r[j];
            if (!c[6]) m[j] = r[j];
            else if (w) m[16*j +: 16] = {16{r[j]}};
            else m[8*j +: 8] = {8{r[j]}};
        end
        return m;
    endfunction

    function automatic logic [127:0] str(string s);
        logic [127:0] d = '0;
        for (int i = 0; i < s.len() && i < 16; i++) d[8*i +: 8] = s[i];
        return d;
    endfunction

    // ---------------- driver ----------------
    task automatic send(logic [7:0] c, logic [127:0] a, logic [63:0] la,
                        logic [127:0] b, logic [63:0] lb, bit wide, string tag);
        item_t it;
        @(negedge clk);
        ctrl = c; a_data = a; a_len = la; b_data = b; b_len = lb; len_wide = wide;
        in_valid = 1'b1;
        it.exp = model(c, a, la, b, lb, wide);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(int cycles);
        @(negedge clk);
        in_valid = 1'b0;
        a_data = ~a_data; b_data = ~b_data; ctrl = ~ctrl;
        repeat (cycles - 1) @(negedge clk);
    endtask

    task automatic check(bit ok, string tag, logic [127:0] got, logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10 result-valid without strobe", 128'(out_valid), 128'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(out_mask === it.exp, it.tag, out_mask, it.exp);
                last_exp = it.exp;
            end
        end
    end

    function automatic logic [127:0] rnd_data();
        logic [7:0] pool [5] = '{8'h00, 8'h01, 8'h7f, 8'h80, 8'hff};
        logic [127:0] d;
        for (int i = 0; i < 16; i++) d[8*i +: 8] = pool[$urandom_range(0, 4)];
        return d;
    endfunction

    function automatic logic [63:0] rnd_len();
        case ($urandom_range(0, 5))
            0: return 64'($signed(-$urandom_range(0, 20)));
            1: return 64'($urandom_range(0, 20));
            2: return {$urandom(), $urandom()};
            3: return {$urandom(), 32'($signed(-$urandom_range(0, 20)))};
            4: return 64'h8000_0000_0000_0000;
            default: return 64'($urandom_range(0, 17));
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(out_valid === 1'b0, "R10 reset valid", 128'(out_valid), 128'd0);
        check(out_mask === '0, "R10 reset mask", out_mask, 128'd0);

        // R3: equal-any, bytes
        send(8'h00, str("aeiou"), 64'd5, str("hello world"), 64'd11, 1'b1, "R3 equal-any");
        // R4: ranges, signed and unsigned bytes
        send(8'h06, {96'h0, 8'h7f, 8'h10, 8'hf0, 8'h80}, 64'd4,
             {64'h0, 64'h90ff_0010_2070_7f81}, 64'd8, 1'b1, "R4 ranges signed");
        send(8'h04, {96'h0, 8'h7f, 8'h10, 8'hf0, 8'h80}, 64'd4,
             {64'h0, 64'h90ff_0010_2070_7f81}, 64'd8, 1'b1, "R4 ranges unsigned");
        // R5: equal-each with mismatched lengths
        send(8'h08, str("abcdefg"), 64'd3, str("abXdefg"), 64'd5, 1'b1, "R5 equal-each");
        // R6: equal-ordered substring search
        send(8'h0c, str("lo"), 64'd2, str("hello lollo"), 64'd11, 1'b1, "R6 equal-ordered");
        send(8'h0c, str("ab"), 64'd2, str("xxxxxxxxxxxxxxxa"), 64'd16, 1'b1, "R6 partial tail");
        // R1: word elements
        send(8'h01, {16'h1, 16'h2, 16'h3, 16'h4, 16'h5, 16'h6, 16'h7, 16'h8}, 64'd8,
             {16'h8, 16'h9, 16'h3, 16'h0, 16'h5, 16'h0, 16'h7, 16'h1}, 64'd8, 1'b1, "R1 words");
        // R2: negative, saturated and narrow lengths
        send(8'h08, str("abcdefghijklmnop"), -64'sd5, str("abcdefghijklmnop"), 64'd5, 1'b1,
             "R2 negative length");
        send(8'h08, str("abcdefghijklmnop"), 64'd100, str("abcdefghijklmnop"), -64'sd100, 1'b1,
             "R2 saturation");
        send(8'h08, str("abcdefghijklmnop"), 64'h8000_0000_0000_0000,
             str("abcdefghijklmnop"), 64'd3, 1'b1, "R2 most negative");
        send(8'h08, str("abcdefghijklmnop"), 64'hdead_beef_0000_0004,
             str("abcdefghijklmnop"), 64'h1234_5678_ffff_fffa, 1'b0, "R2 narrow upper ignored");
        // R7: polarity values
        send(8'h10, str("aeiou"), 64'd5, str("hello"), 64'd5, 1'b1, "R7 invert all");
        send(8'h30, str("aeiou"), 64'd5, str("hello"), 64'd5, 1'b1, "R7 invert valid");
        send(8'h20, str("aeiou"), 64'd5, str("hello"), 64'd5, 1'b1, "R7 polarity 10");
        // R8 compact word mode with full inversion; R9 expansion
        send(8'h19, str("aabb"), 64'd2, str("aabbccdd"), 64'd8, 1'b1, "R8 compact words");
        send(8'h40, str("aeiou"), 64'd5, str("hello world"), 64'd11, 1'b1, "R9 byte expand");
        send(8'h4d, str("ab"), 64'd2, str("xxabxxab"), 64'd16, 1'b1, "R9 word expand");
        // R11: control bit 7 ignored
        send(8'h80, str("aeiou"), 64'd5, str("hello world"), 64'd11, 1'b1, "R11 bit7 set");
        send(8'hcc, str("lo"), 64'd2, str("hello lollo"), 64'd11, 1'b1, "R11 bit7 ordered");
        idle(4);
        // R10: mask held and no valid while idle
        check(out_valid === 1'b0, "R10 idle valid", 128'(out_valid), 128'd0);
        check(out_mask === last_exp, "R10 idle hold", out_mask, last_exp);

        // Mixed stimulus over all control bytes and length shapes
        for (int t = 0; t < 1500; t++) begin
            logic [7:0] c;
            string tg;
            c = 8'($urandom());
            case (c[3:2])
                2'b00: tg = "R3 random";
                2'b01: tg = "R4 random";
                2'b10: tg = "R5 random";
                default: tg = "R6 random";
            endcase
            send(c, rnd_data(), rnd_len(), rnd_data(), rnd_len(), 1'($urandom()), tg);
            if (($urandom() & 7) == 0) idle(2);
        end
        idle(3);
        check(sb_q.size() == 0, "R10 all results delivered", 128'(sb_q.size()), 128'd0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule